// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps track of instructions that have been issued but not yet retired. It is a circular queue of entries. At issue, the front end reserves the entry at the tail and receives that entry's index as a tag. The execution units later hand the tag back on one of several writeback ports, together with a result and a fault flag. Results may come back in any order. Retirement only looks at the oldest entry, the head. The head retires once it is complete, and a retiring entry of a register-writing kind produces a write strobe toward the architectural register file. No other path writes architectural state.

A fault is reported only when the faulting entry becomes the oldest. At that point the block raises an exception pulse, writes nothing, and drops every entry still in the queue. An external flush input, used for branch mispredicts, also drops every entry in one cycle. After either kind of discard, both pointers return to slot zero. Entry kinds are encoded in two bits: 0 is an arithmetic op, 1 is a load, 2 is a store and 3 is a branch. Only kinds 0 and 1 write a register.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the queue is empty. `robEmpty` is 1, `allocReady` is 1, `allocIdx` is 0, and neither `commitValid` nor `excRaise` is asserted.
- R2: An accepted allocation (`allocReq` and `allocReady` both high at a clock edge) takes slot `allocIdx`. Consecutive allocations receive consecutive indices modulo DEPTH.
- R3: After DEPTH allocations with no retirement, `robFull` is 1 and `allocReady` is 0, unless the head retires in that same cycle. A request made while allocation is refused changes neither the tail nor the contents.
- R4: A writeback on any port, to a valid entry, records the result and the fault flag and marks the entry complete. All ports act in the same cycle, and entries may complete in any order.
- R5: Only the head can retire. It retires in the cycle it is complete and carries no fault. A complete younger entry waits while an older one is still pending. An empty queue never retires.
- R6: `rfWe` is asserted only together with `commitValid`, and only for kinds 0 (arithmetic) and 1 (load). Kinds 2 (store) and 3 (branch) retire with `rfWe` at 0.
- R7: A complete head whose fault flag is set raises `excRaise` for one cycle, with `commitValid` and `rfWe` at 0 and `allocReady` at 0. On the next cycle the queue is empty and `allocIdx` is 0.
- R8: `flushIn` empties the queue on the next cycle, with `allocIdx` at 0. In the flush cycle, retirement, allocation and writebacks are all ignored.
- R9: When the queue is full and the head retires, an allocation in the same cycle is accepted into the slot being freed.
- R10: A writeback whose index names an entry that is not valid has no effect. An entry allocated into that slot later starts incomplete.
- R11: During a retirement, `commitIdx`, `commitKind`, `rfAddr` and `rfData` show the head's slot, kind, destination register and recorded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request to reserve the tail entry |
| allocKind | input | 2 | Kind of the issuing instruction (0 arith, 1 load, 2 store, 3 branch) |
| allocDest | input | REG_W | Destination register of the issuing instruction |
| allocReady | output | 1 | Allocation is accepted this cycle |
| allocIdx | output | IDX_W | Slot that an allocation in this cycle receives |
| wbValid | input | NUM_WB | Per-port writeback strobe |
| wbIdx | input | NUM_WB*IDX_W | Per-port target slot, port p at bits p*IDX_W |
| wbData | input | NUM_WB*DATA_W | Per-port result value |
| wbExc | input | NUM_WB | Per-port fault flag |
| flushIn | input | 1 | Discard every entry (mispredict) |
| robEmpty | output | 1 | No entry in flight |
| robFull | output | 1 | All DEPTH entries in flight |
| commitValid | output | 1 | Head retires normally this cycle |
| commitIdx | output | IDX_W | Slot of the head entry |
| commitKind | output | 2 | Kind of the head entry |
| rfWe | output | 1 | Register-file write strobe |
| rfAddr | output | REG_W | Register-file write address |
| rfData | output | DATA_W | Register-file write data |
| excRaise | output | 1 | Faulting head reached; queue discarded |

## Verification
The directed part of the bench fills the queue to full and then allocates and retires in the same cycle. A design that tested only the full flag would lose that cycle of throughput, and one with careless write priority would free the slot it had just refilled. Results are completed out of order on both ports, with a younger entry ready before the head. A design that retired any complete entry would write registers in the wrong order. A faulting head is placed behind normal entries. The bench checks that nothing is written in that cycle and that the queue is empty afterwards, which catches a design that reports a fault at writeback or keeps entries younger than the fault. Writebacks that arrive together with a flush, or that target a slot that is not valid, must leave that slot incomplete once it is reallocated. A design that did not gate on the valid bit would retire a stale result. Random traffic with wrap-around and occasional flushes is compared against a reference model kept in the bench.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } instrKind_e;

  // strobes from control to the entry store
  typedef struct packed {
    logic alloc;
    logic retire;
    logic discard;
  } robStrobe_t;

  function automatic logic kindWritesReg(instrKind_e k);
    return (k == KIND_ALU) || (k == KIND_LOAD);
  endfunction

endpackage

// File: rtl/reorder_ctrl.sv
module reorder_ctrl
  import reorder_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             allocReq,
  input  logic             flushIn,
  input  logic             headReady,
  input  logic             headExc,
  output robStrobe_t       strb,
  output logic [IDX_W-1:0] allocSlot,
  output logic [IDX_W-1:0] headSlot,
  output logic             allocReady,
  output logic             commitFire,
  output logic             excFire,
  output logic             robEmpty,
  output logic             robFull
);

  // pointers carry one extra wrap bit to tell full from empty
  logic [IDX_W:0] headPtr;
  logic [IDX_W:0] tailPtr;
  logic           headDone;
  logic           discardAll;
  logic           allocFire;

  assign robEmpty   = (headPtr == tailPtr);
  assign robFull    = (headPtr[IDX_W] != tailPtr[IDX_W]) &&
                      (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]);
  assign headDone   = !robEmpty && headReady;
  assign commitFire = headDone && !flushIn && !headExc;
  assign excFire    = headDone && !flushIn && headExc;
  assign discardAll = flushIn || excFire;
  assign allocReady = !discardAll && (!robFull || commitFire);
  assign allocFire  = allocReq && allocReady;

  assign allocSlot  = tailPtr[IDX_W-1:0];
  assign headSlot   = headPtr[IDX_W-1:0];

  assign strb.alloc   = allocFire;
  assign strb.retire  = commitFire;
  assign strb.discard = discardAll;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (discardAll) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (commitFire) headPtr <= headPtr + 1'b1;
      if (allocFire)  tailPtr <= tailPtr + 1'b1;
    end
  end

endmodule

// File: rtl/reorder_store.sv
module reorder_store
  import reorder_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int NUM_WB = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  robStrobe_t               strb,
  input  logic [IDX_W-1:0]         allocSlot,
  input  logic [IDX_W-1:0]         headSlot,
  input  instrKind_e               allocKind,
  input  logic [REG_W-1:0]         allocDest,
  input  logic [NUM_WB-1:0]        wbValid,
  input  logic [NUM_WB*IDX_W-1:0]  wbIdx,
  input  logic [NUM_WB*DATA_W-1:0] wbData,
  input  logic [NUM_WB-1:0]        wbExc,
  output logic                     headReady,
  output logic                     headExc,
  output instrKind_e               headKind,
  output logic [REG_W-1:0]         headDest,
  output logic [DATA_W-1:0]        headData
);

  logic              entValid [DEPTH];
  logic              entReady [DEPTH];
  logic              entExc   [DEPTH];
  instrKind_e        entKind  [DEPTH];
  logic [REG_W-1:0]  entDest  [DEPTH];
  logic [DATA_W-1:0] entData  [DEPTH];

  logic [IDX_W-1:0]  wbSlot [NUM_WB];
  logic [DATA_W-1:0] wbVal  [NUM_WB];

  for (genvar g = 0; g < NUM_WB; g++) begin : gUnpack
    assign wbSlot[g] = wbIdx[g*IDX_W +: IDX_W];
    assign wbVal[g]  = wbData[g*DATA_W +: DATA_W];
  end

  // later writes in this block take priority: writeback, then retire, then allocate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entReady[i] <= 1'b0;
        entExc[i]   <= 1'b0;
        entKind[i]  <= KIND_ALU;
        entDest[i]  <= '0;
        entData[i]  <= '0;
      end
    end else if (strb.discard) begin
      for (int i = 0; i < DEPTH; i++) begin
        entValid[i] <= 1'b0;
        entReady[i] <= 1'b0;
        entExc[i]   <= 1'b0;
      end
    end else begin
      for (int p = 0; p < NUM_WB; p++) begin
        if (wbValid[p] && entValid[wbSlot[p]]) begin
          entReady[wbSlot[p]] <= 1'b1;
          entExc[wbSlot[p]]   <= wbExc[p];
          entData[wbSlot[p]]  <= wbVal[p];
        end
      end
      if (strb.retire) begin
        entValid[headSlot] <= 1'b0;
        entReady[headSlot] <= 1'b0;
      end
      if (strb.alloc) begin
        entValid[allocSlot] <= 1'b1;
        entReady[allocSlot] <= 1'b0;
        entExc[allocSlot]   <= 1'b0;
        entKind[allocSlot]  <= allocKind;
        entDest[allocSlot]  <= allocDest;
      end
    end
  end

  assign headReady = entValid[headSlot] && entReady[headSlot];
  assign headExc   = entExc[headSlot];
  assign headKind  = entKind[headSlot];
  assign headDest  = entDest[headSlot];
  assign headData  = entData[headSlot];

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
  import reorder_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int NUM_WB = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     allocReq,
  input  logic [1:0]               allocKind,
  input  logic [REG_W-1:0]         allocDest,
  output logic                     allocReady,
  output logic [IDX_W-1:0]         allocIdx,
  input  logic [NUM_WB-1:0]        wbValid,
  input  logic [NUM_WB*IDX_W-1:0]  wbIdx,
  input  logic [NUM_WB*DATA_W-1:0] wbData,
  input  logic [NUM_WB-1:0]        wbExc,
  input  logic                     flushIn,
  output logic                     robEmpty,
  output logic                     robFull,
  output logic                     commitValid,
  output logic [IDX_W-1:0]         commitIdx,
  output logic [1:0]               commitKind,
  output logic                     rfWe,
  output logic [REG_W-1:0]         rfAddr,
  output logic [DATA_W-1:0]        rfData,
  output logic                     excRaise
);

  robStrobe_t       strb;
  logic [IDX_W-1:0] headSlot;
  logic             headReady;
  logic             headExc;
  instrKind_e       headKind;
  logic             commitFire;

  reorder_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .allocReq  (allocReq),
    .flushIn   (flushIn),
    .headReady (headReady),
    .headExc   (headExc),
    .strb      (strb),
    .allocSlot (allocIdx),
    .headSlot  (headSlot),
    .allocReady(allocReady),
    .commitFire(commitFire),
    .excFire   (excRaise),
    .robEmpty  (robEmpty),
    .robFull   (robFull)
  );

  reorder_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .REG_W (REG_W),
    .NUM_WB(NUM_WB)
  ) store_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .allocSlot(allocIdx),
    .headSlot (headSlot),
    .allocKind(instrKind_e'(allocKind)),
    .allocDest(allocDest),
    .wbValid  (wbValid),
    .wbIdx    (wbIdx),
    .wbData   (wbData),
    .wbExc    (wbExc),
    .headReady(headReady),
    .headExc  (headExc),
    .headKind (headKind),
    .headDest (rfAddr),
    .headData (rfData)
  );

  assign commitValid = commitFire;
  assign commitIdx   = headSlot;
  assign commitKind  = headKind;
  assign rfWe        = commitFire && kindWritesReg(headKind);

endmodule

// File: rtl/reorder_buffer_chk.sv
module reorder_buffer_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             allocReq,
  input logic             allocReady,
  input logic [IDX_W-1:0] allocIdx,
  input logic             flushIn,
  input logic             robEmpty,
  input logic             robFull,
  input logic             commitValid,
  input logic [IDX_W-1:0] commitIdx,
  input logic             rfWe,
  input logic             excRaise
);

  AST_ALLOC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    allocReq && allocReady |=> allocIdx == IDX_W'($past(allocIdx) + 1'b1)); // R2

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    robFull && !commitValid |-> !allocReady); // R3

  AST_FULL_SAME_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    robFull |-> allocIdx == commitIdx); // R3

  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    robEmpty |-> !commitValid && !excRaise); // R5

  AST_HEAD_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> commitIdx == IDX_W'($past(commitIdx) + 1'b1)); // R5

  AST_WRITE_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> commitValid); // R6

  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitValid, excRaise})); // R7

  AST_EXC_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    excRaise |=> robEmpty && allocIdx == '0); // R7

  AST_FLUSH_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    flushIn |=> robEmpty && allocIdx == '0); // R8

endmodule

bind reorder_buffer reorder_buffer_chk #(.IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .allocReq   (allocReq),
  .allocReady (allocReady),
  .allocIdx   (allocIdx),
  .flushIn    (flushIn),
  .robEmpty   (robEmpty),
  .robFull    (robFull),
  .commitValid(commitValid),
  .commitIdx  (commitIdx),
  .rfWe       (rfWe),
  .excRaise   (excRaise)
);

// File: tb/reorder_buffer_tb_top.sv
module reorder_buffer_tb_top;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int REG_W  = 5;
  localparam int NUM_WB = 2;
  localparam int IDX_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocReq;
  logic [1:0] allocKind;
  logic [REG_W-1:0] allocDest;
  logic allocReady;
  logic [IDX_W-1:0] allocIdx;
  logic [NUM_WB-1:0] wbValid;
  logic [NUM_WB*IDX_W-1:0] wbIdx;
  logic [NUM_WB*DATA_W-1:0] wbData;
  logic [NUM_WB-1:0] wbExc;
  logic flushIn;
  logic robEmpty, robFull, commitValid, rfWe, excRaise;
  logic [IDX_W-1:0] commitIdx;
  logic [1:0] commitKind;
  logic [REG_W-1:0] rfAddr;
  logic [DATA_W-1:0] rfData;

  always #4 clk = ~clk;

  reorder_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W), .NUM_WB(NUM_WB)) dut_i (
    .clk(clk), .rstN(rstN), .allocReq(allocReq), .allocKind(allocKind),
    .allocDest(allocDest), .allocReady(allocReady), .allocIdx(allocIdx),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData), .wbExc(wbExc),
    .flushIn(flushIn), .robEmpty(robEmpty), .robFull(robFull),
    .commitValid(commitValid), .commitIdx(commitIdx), .commitKind(commitKind),
    .rfWe(rfWe), .rfAddr(rfAddr), .rfData(rfData), .excRaise(excRaise)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model
  bit               mValid [DEPTH];
  bit               mReady [DEPTH];
  bit               mExc   [DEPTH];
  logic [1:0]       mKind  [DEPTH];
  logic [REG_W-1:0] mDest  [DEPTH];
  logic [DATA_W-1:0] mData [DEPTH];
  int mHead = 0, mTail = 0, mCount = 0;

  function automatic bit writesReg(logic [1:0] k);
    return k < 2'd2;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    allocReq = 1'b0; allocKind = 2'd0; allocDest = '0;
    wbValid = '0; wbIdx = '0; wbData = '0; wbExc = '0; flushIn = 1'b0;
  endtask

  task automatic setWb(int p, int idx, logic [DATA_W-1:0] d, bit e);
    wbValid[p] = 1'b1;
    wbIdx[p*IDX_W +: IDX_W] = IDX_W'(idx);
    wbData[p*DATA_W +: DATA_W] = d;
    wbExc[p] = e;
  endtask

  task automatic doAlloc(logic [1:0] k, logic [REG_W-1:0] d);
    allocReq = 1'b1; allocKind = k; allocDest = d;
  endtask

  function automatic void modelClear();
    for (int i = 0; i < DEPTH; i++) begin
      mValid[i] = 0; mReady[i] = 0; mExc[i] = 0;
    end
    mHead = 0; mTail = 0; mCount = 0;
  endfunction

  // one clock: compare outputs against model, clock, update model
  task automatic step();
    bit done, expC, expE, flAll, expAR;
    #1;
    done  = (mCount > 0) && mReady[mHead];
    expC  = done && !flushIn && !mExc[mHead];
    expE  = done && !flushIn && mExc[mHead];
    flAll = flushIn || expE;
    expAR = !flAll && ((mCount < DEPTH) || expC);
    chk("R5 commitValid", commitValid, expC);
    chk("R7 excRaise", excRaise, expE);
    chk("R3 allocReady", allocReady, expAR);
    chk("R2 allocIdx", allocIdx, mTail);
    chk("R1 robEmpty", robEmpty, mCount == 0);
    chk("R3 robFull", robFull, mCount == DEPTH);
    if (expC) begin
      chk("R11 commitIdx", commitIdx, mHead);
      chk("R11 rfAddr", rfAddr, mDest[mHead]);
      chk("R11 rfData", rfData, mData[mHead]);
      chk("R11 commitKind", commitKind, mKind[mHead]);
      chk("R6 rfWe", rfWe, writesReg(mKind[mHead]));
    end else begin
      chk("R6 rfWe idle", rfWe, 1'b0);
    end
    @(posedge clk);
    if (flAll) modelClear();
    else begin
      for (int p = 0; p < NUM_WB; p++) begin
        int ix;
        ix = int'(wbIdx[p*IDX_W +: IDX_W]);
        if (wbValid[p] && mValid[ix]) begin
          mReady[ix] = 1; mExc[ix] = wbExc[p]; mData[ix] = wbData[p*DATA_W +: DATA_W];
        end
      end
      if (expC) begin
        mValid[mHead] = 0; mReady[mHead] = 0;
        mHead = (mHead + 1) % DEPTH; mCount--;
      end
      if (allocReq && expAR) begin
        mValid[mTail] = 1; mReady[mTail] = 0; mExc[mTail] = 0;
        mKind[mTail] = allocKind; mDest[mTail] = allocDest;
        mTail = (mTail + 1) % DEPTH; mCount++;
      end
    end
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    modelClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 reset allocReady", allocReady, 1'b1);
    chk("R1 reset allocIdx", allocIdx, 0);
    chk("R1 reset robEmpty", robEmpty, 1'b1);
    chk("R1 reset commitValid", commitValid, 1'b0);
    chk("R1 reset excRaise", excRaise, 1'b0);

    // R2 fill in order, slot 3 is a store
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 consecutive allocIdx", allocIdx, i);
      doAlloc((i == 3) ? 2'd2 : 2'd0, REG_W'(i + 1));
      step();
    end
    chk("R3 full flag", robFull, 1'b1);
    chk("R3 full refuses", allocReady, 1'b0);
    doAlloc(2'd1, 5'd30);
    step();
    chk("R3 refused request keeps tail", allocIdx, 0);
    chk("R3 still full", robFull, 1'b1);

    // R4 out-of-order completion on both ports, R5 head not done
    setWb(0, 2, 32'h22, 0);
    setWb(1, 1, 32'h11, 0);
    step();
    chk("R5 younger done head pending", commitValid, 1'b0);
    setWb(0, 0, 32'hA0, 0);
    step();
    chk("R11 head retires idx", commitIdx, 0);
    chk("R11 head data", rfData, 32'hA0);
    chk("R11 head dest", rfAddr, 5'd1);
    chk("R6 arith writes", rfWe, 1'b1);
    // R9 allocate into the slot being freed while full
    doAlloc(2'd3, 5'd9);
    #1;
    chk("R9 full plus retire accepts", allocReady, 1'b1);
    step();
    chk("R9 still full after swap", robFull, 1'b1);
    chk("R4 second result", rfData, 32'h11);
    step();
    chk("R4 third result", rfData, 32'h22);
    step();
    chk("R5 pending head blocks", commitValid, 1'b0);
    setWb(1, 3, 32'h33, 0);
    step();
    chk("R6 store retires", commitValid, 1'b1);
    chk("R6 store no write", rfWe, 1'b0);
    chk("R6 store kind", commitKind, 2'd2);
    step();
    // R7 fault behind a normal entry
    setWb(0, 5, 32'hBAD, 1);
    setWb(1, 4, 32'h44, 0);
    step();
    chk("R7 entry before fault writes", rfWe, 1'b1);
    step();
    doAlloc(2'd0, 5'd7);
    #1;
    chk("R7 fault raised", excRaise, 1'b1);
    chk("R7 no commit on fault", commitValid, 1'b0);
    chk("R7 no write on fault", rfWe, 1'b0);
    chk("R7 alloc refused on fault", allocReady, 1'b0);
    step();
    chk("R7 emptied", robEmpty, 1'b1);
    chk("R7 pointer home", allocIdx, 0);

    // R8 flush with concurrent writeback and allocation
    for (int i = 0; i < 3; i++) begin doAlloc(2'd1, REG_W'(i)); step(); end
    flushIn = 1'b1;
    doAlloc(2'd0, 5'd3);
    setWb(0, 0, 32'h55, 0);
    step();
    chk("R8 flush empties", robEmpty, 1'b1);
    chk("R8 flush pointer home", allocIdx, 0);
    doAlloc(2'd0, 5'd4);
    step();
    step();
    chk("R8 writeback in flush ignored", commitValid, 1'b0);

    // R10 writeback to an invalid slot
    setWb(1, 1, 32'h77, 0);
    step();
    doAlloc(2'd0, 5'd5);
    step();
    setWb(0, 0, 32'h66, 0);
    step();
    step();
    chk("R10 head moved", commitIdx, 1);
    chk("R10 stale writeback ignored", commitValid, 1'b0);
    flushIn = 1'b1;
    step();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 100) < 55) doAlloc(2'($urandom % 4), REG_W'($urandom));
      for (int p = 0; p < NUM_WB; p++) begin
        int r;
        r = $urandom % 100;
        if (r < 45 && mCount > 0) begin
          int ix;
          ix = (mHead + int'($urandom % mCount)) % DEPTH;
          if (!mReady[ix]) setWb(p, ix, $urandom, ($urandom % 20) == 0);
        end else if (r < 50) begin
          setWb(p, int'($urandom % DEPTH), $urandom, 0);
        end
      end
      flushIn = (($urandom % 64) == 0);
      step();
    end
    finish();
  end
endmodule